// File: doc/BRIEF.md
# Parallel EPROM Bank Read Sequencer

This block sits on the host side of a bank of asynchronous byte-wide EPROMs that share one address bus, one data bus and one output-enable line. A host asks for a byte by raising `req_i` with a word address. The bits above the per-device address field pick one device. The sequencer pulls that device's chip enable low and drives the low address bits onto the shared address bus. It lowers the common output enable only once the allowed slack has passed, counts out the worst-case access delay in clock cycles, and then captures the data bus.

At the capture edge it hands the byte back with a one-cycle `rvalid_o` pulse and releases both enables together. It then stays busy for the bus-float interval, so the next device cannot drive the bus while the previous one is still turning off. The four device delays (address access, chip-enable access, output-enable access and output float) are given in nanoseconds. Each is converted to cycles from the clock-period parameter by rounding up, with a minimum of one cycle.

Between accesses every chip enable is inactive, which keeps the idle devices in their low-power state.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, and whenever `busy_o` is low, every bit of `mem_ce_no` is 1, `mem_oe_no` is 1 and `rvalid_o` is 0.
- R2: For an accepted address, the field above the low `DEV_AW` bits is a device index i. During the access only `mem_ce_no[i]` is 0, and `mem_addr_o` equals the low `DEV_AW` bits of the address.
- R3: Each delay becomes cycles as ceil(t_ns / CLK_PERIOD_NS), with at least 1. Let ACC, CE, OE and DF be the results. SLACK = ACC − OE, or 0 if that is negative. TOTAL = max(ACC, CE, SLACK + OE).
- R4: `mem_oe_no` goes low SLACK cycles after the chip enable goes low. It then stays low until release, so it is low for TOTAL − SLACK cycles.
- R5: Take the accepting clock edge as edge 0. The data bus is captured at edge TOTAL and appears on `rdata_o`, and `rvalid_o` is high for exactly the one cycle after that edge.
- R6: Chip enable and output enable both return high at the capture edge, so both are high while `rvalid_o` is high.
- R7: After the release, `busy_o` stays high for DF cycles. No chip enable goes low again until at least DF cycles after the release.
- R8: A request is taken only at an edge where `req_i` is 1 and `busy_o` is 0. A request that is held high while busy starts exactly one cycle after the float interval ends.
- R9: At most one chip enable is low at a time, and output enable is low only while a chip enable is low.
- R10: `rdata_o` keeps its value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| addr_i | input | DEV_AW+SEL_W | Word address: device index above the device address |
| busy_o | output | 1 | Access or float interval in progress |
| rdata_o | output | DW | Captured byte |
| rvalid_o | output | 1 | One-cycle pulse when `rdata_o` is updated |
| mem_addr_o | output | DEV_AW | Shared device address bus |
| mem_ce_no | output | NUM_DEV | Per-device chip enable, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_data_i | input | DW | Shared device data bus |

## Verification
The bench stands in for the devices with a model that drives the correct byte only after the chip-enable, address and output-enable times have each been met, and drives the inverted byte otherwise. A sequencer that samples even one cycle early, or lowers output enable too late, therefore returns a wrong byte on that same read. A wrong count in the float phase shows at the ports as a shortened gap between two chip-enable windows, caught on the first back-to-back read. A bad decode shows within one cycle of acceptance, either as the wrong enable line or as two enable lines low at once.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               en_i,
  output logic [NUM_DEV-1:0] ce_no
);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_ce
    assign ce_no[i] = !(en_i && (sel_i == SEL_W'(i)));
  end

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int unsigned SLACK_CYC = 5,
  parameter int unsigned TOTAL_CYC = 10,
  parameter int unsigned FLOAT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic ce_act_o,
  output logic oe_no,
  output logic sample_o
);

  localparam int unsigned MAX_CYC = max2(TOTAL_CYC, FLOAT_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  rd_state_e        state_q;
  logic [CNT_W-1:0] tick_q;
  logic             float_done;

  assign busy_o     = (state_q != ST_IDLE);
  assign sample_o   = (state_q == ST_ACCESS) && (tick_q == CNT_W'(TOTAL_CYC - 1));
  assign float_done = (state_q == ST_FLOAT) && (tick_q == CNT_W'(FLOAT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tick_q   <= '0;
      ce_act_o <= 1'b0;
      oe_no    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_ACCESS;
            tick_q   <= '0;
            ce_act_o <= 1'b1;
            oe_no    <= (SLACK_CYC != 0);
          end
        end
        ST_ACCESS: begin
          tick_q <= tick_q + 1'b1;
          if (sample_o) begin
            state_q  <= ST_FLOAT;
            tick_q   <= '0;
            ce_act_o <= 1'b0;
            oe_no    <= 1'b1;
          end else if (tick_q + 1'b1 == CNT_W'(SLACK_CYC)) begin
            oe_no <= 1'b0;
          end
        end
        ST_FLOAT: begin
          tick_q <= tick_q + 1'b1;
          if (float_done) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_OE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> ce_act_o); // R9
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLOAT) |=> !ce_act_o); // R7
  AST_CE_RELEASE_AT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (!ce_act_o && oe_no)); // R6

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int unsigned NUM_DEV       = 4,
  parameter int unsigned DEV_AW        = 17,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_ACC_NS      = 100,
  parameter int unsigned T_CE_NS       = 100,
  parameter int unsigned T_OE_NS       = 50,
  parameter int unsigned T_DF_NS       = 40,
  localparam int unsigned SEL_W        = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int unsigned AW           = DEV_AW + SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [AW-1:0]      addr_i,
  output logic               busy_o,
  output logic [DW-1:0]      rdata_o,
  output logic               rvalid_o,
  output logic [DEV_AW-1:0]  mem_addr_o,
  output logic [NUM_DEV-1:0] mem_ce_no,
  output logic               mem_oe_no,
  input  logic [DW-1:0]      mem_data_i
);

  localparam int unsigned ACC_CYC   = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned CE_CYC    = ns_to_cyc(T_CE_NS, CLK_PERIOD_NS);
  localparam int unsigned OE_CYC    = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
  localparam int unsigned DF_CYC    = ns_to_cyc(T_DF_NS, CLK_PERIOD_NS);
  localparam int unsigned SLACK_CYC = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 0;
  localparam int unsigned TOTAL_CYC = max2(max2(ACC_CYC, CE_CYC), SLACK_CYC + OE_CYC);

  logic              start;
  logic              ce_act;
  logic              sample;
  logic [SEL_W-1:0]  sel_q;
  logic [DEV_AW-1:0] addr_q;
  logic [DW-1:0]     rdata_q;
  logic              rvalid_q;

  assign start = req_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      addr_q <= '0;
    end else if (start) begin
      sel_q  <= addr_i[DEV_AW +: SEL_W];
      addr_q <= addr_i[DEV_AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sample;
      if (sample) rdata_q <= mem_data_i;
    end
  end

  eprom_rd_seq #(
    .SLACK_CYC(SLACK_CYC),
    .TOTAL_CYC(TOTAL_CYC),
    .FLOAT_CYC(DF_CYC)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy_o),
    .ce_act_o(ce_act),
    .oe_no   (mem_oe_no),
    .sample_o(sample)
  );

  eprom_ce_decode #(
    .NUM_DEV(NUM_DEV),
    .SEL_W  (SEL_W)
  ) i_dec (
    .sel_i(sel_q),
    .en_i (ce_act),
    .ce_no(mem_ce_no)
  );

  assign mem_addr_o = addr_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;

  AST_ONE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~mem_ce_no) <= 1); // R9
  AST_IDLE_NO_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (&mem_ce_no && mem_oe_no && !rvalid_o)); // R1
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R5
  AST_RELEASED_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (&mem_ce_no && mem_oe_no)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> $stable(rdata_o)); // R10

endmodule

// File: tb/test_eprom_rd_ctrl.sv
module test_eprom_rd_ctrl;

  localparam int CLK_PERIOD_NS = 16;
  localparam int NUM_DEV = 4;
  localparam int DEV_AW  = 17;
  localparam int SEL_W   = 2;
  localparam int AW      = DEV_AW + SEL_W;
  localparam int T_ACC = 100, T_CE = 100, T_OE = 50, T_DF = 40;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_ACC = (T_ACC + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int E_CE  = (T_CE + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int E_OE  = (T_OE + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  int acc_c, ce_c, oe_c, df_c, slack_c, total_c;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic busy, rvalid, oe_n;
  logic [7:0] rdata;
  logic [7:0] mdata = 8'h00;
  logic [DEV_AW-1:0] maddr;
  logic [NUM_DEV-1:0] ce_n;

  int nvec = 0, nerr = 0;

  eprom_rd_ctrl #(
    .NUM_DEV(NUM_DEV), .DEV_AW(DEV_AW), .DW(8), .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_ACC_NS(T_ACC), .T_CE_NS(T_CE), .T_OE_NS(T_OE), .T_DF_NS(T_DF)
  ) i_eprom_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .busy_o(busy),
    .rdata_o(rdata), .rvalid_o(rvalid), .mem_addr_o(maddr), .mem_ce_no(ce_n),
    .mem_oe_no(oe_n), .mem_data_i(mdata)
  );

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  function automatic logic [7:0] model_byte(input int dev, input logic [DEV_AW-1:0] a);
    return a[7:0] ^ {a[16:13], a[11:8]} ^ 8'(dev * 8'h35 + 8'h11);
  endfunction

  task automatic chk(input string req_tag, input logic ok, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  // device bank model and bus monitors, evaluated away from the active edge
  int ce_cnt = 0, oe_cnt = 0, rel_cnt = 1000;
  logic prev_any = 1'b0;
  always @(negedge clk) begin
    int dev;
    int n;
    n = 0; dev = -1;
    for (int i = 0; i < NUM_DEV; i++) if (!ce_n[i]) begin n++; dev = i; end
    if (n > 1) chk("R9 multiple chip enables", 1'b0, n, 1);
    if (!oe_n && n == 0) chk("R9 output enable without chip enable", 1'b0, 0, 1);
    if (n == 1 && !prev_any && rel_cnt < df_c) chk("R7 float gap", 1'b0, rel_cnt, df_c);
    ce_cnt  = (n == 1) ? ce_cnt + 1 : 0;
    oe_cnt  = (n == 1 && !oe_n) ? oe_cnt + 1 : 0;
    rel_cnt = (n == 0) ? rel_cnt + 1 : 0;
    prev_any = (n != 0);
    if (dev >= 0 && ce_cnt >= E_ACC && ce_cnt >= E_CE && oe_cnt >= E_OE)
      mdata = model_byte(dev, maddr);
    else if (dev >= 0)
      mdata = ~model_byte(dev, maddr);
    else
      mdata = 8'h00;
  end

  task automatic do_read(input int dev, input logic [DEV_AW-1:0] a);
    int k, nce, noe, nb;
    logic [7:0] exp;
    logic [NUM_DEV-1:0] exp_ce;
    exp = model_byte(dev, a);
    exp_ce = ~(NUM_DEV'(1) << dev);
    req = 1'b1; addr = {SEL_W'(dev), a};
    @(negedge clk);
    req = 1'b0;
    chk("R2 chip enable decode", ce_n == exp_ce, ce_n, exp_ce);
    chk("R2 device address", maddr == a, maddr, a);
    k = 1; nce = 0; noe = 0;
    while (!rvalid && k < 100) begin
      if (ce_n != '1) nce++;
      if (!oe_n) noe++;
      @(negedge clk);
      k++;
    end
    chk("R5 latency", k == total_c + 1, k, total_c + 1);
    chk("R5 data", rdata == exp, rdata, exp);
    chk("R4 output enable window", noe == total_c - slack_c, noe, total_c - slack_c);
    chk("R6 release at capture", ce_n == '1 && oe_n, {ce_n, oe_n}, {NUM_DEV'('1), 1'b1});
    nb = 0;
    while (busy && nb < 100) begin
      nb++;
      @(negedge clk);
    end
    chk("R7 busy float", nb == df_c, nb, df_c);
    chk("R5 single pulse", !rvalid, rvalid, 0);
    chk("R10 data held", rdata == exp, rdata, exp);
    chk("R1 idle enables", ce_n == '1 && oe_n, {ce_n, oe_n}, {NUM_DEV'('1), 1'b1});
  endtask

  initial begin
    #(CLK_PERIOD_NS * 200000);
    chk("watchdog", 1'b0, 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int g, nb;
    logic [7:0] e2;
    acc_c = cyc(T_ACC); ce_c = cyc(T_CE); oe_c = cyc(T_OE); df_c = cyc(T_DF);
    slack_c = (acc_c > oe_c) ? acc_c - oe_c : 0;
    total_c = acc_c;
    if (ce_c > total_c) total_c = ce_c;
    if (slack_c + oe_c > total_c) total_c = slack_c + oe_c;
    // R3 conversions: 100/16 -> 7, 50/16 -> 4, 40/16 -> 3
    chk("R3 access cycles", total_c == 7, total_c, 7);
    chk("R3 float cycles", df_c == 3, df_c, 3);
    chk("R3 minimum one cycle", cyc(0) == 1, cyc(0), 1);

    repeat (3) @(negedge clk);
    chk("R1 reset state", ce_n == '1 && oe_n && !busy && !rvalid,
        {ce_n, oe_n, busy, rvalid}, {NUM_DEV'('1), 3'b100});
    rst_ni = 1'b1;
    @(negedge clk);

    for (int d = 0; d < NUM_DEV; d++) begin
      do_read(d, '0);
      do_read(d, '1);
      for (int b = 0; b < DEV_AW; b++) do_read(d, DEV_AW'(1) << b);
      do_read(d, DEV_AW'(17'h0A5C3 + d * 17'h1357));
    end

    // R8: request held through busy, second read starts one cycle after float ends
    req = 1'b1; addr = {SEL_W'(1), DEV_AW'(17'h1ABCD)};
    g = 0;
    while (!rvalid && g < 100) begin @(negedge clk); g++; end
    addr = {SEL_W'(2), DEV_AW'(17'h05555)};
    g = 0;
    while (ce_n == '1 && g < 100) begin g++; @(negedge clk); end
    req = 1'b0;
    chk("R8 held request gap", g == df_c + 1, g, df_c + 1);
    chk("R8 second device", ce_n == 4'b1011, ce_n, 4'b1011);
    g = 0;
    while (!rvalid && g < 100) begin @(negedge clk); g++; end
    e2 = model_byte(2, 17'h05555);
    chk("R8 second data", rdata == e2, rdata, e2);
    nb = 0;
    while (busy && nb < 100) begin nb++; @(negedge clk); end
    repeat (5) @(negedge clk);
    chk("R8 no extra access", ce_n == '1 && !busy, {ce_n, busy}, {NUM_DEV'('1), 1'b0});

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule